// File: doc/BRIEF.md
# CAN Controller Mode Status Tracker

This block follows the operating mode and fault confinement state of a CAN protocol engine and turns them into three global status flags. It watches the transmit and receive error counters, a bus-off indication from the engine and the current bus phase: idle, intermission or inside a frame. From these it derives a single fault flag. That flag covers both error passive and bus off, and the engine's own bus-off indication tells the two apart.

Halt and sleep requests from the control side are granted by a small mode machine. Halt is granted only at a frame boundary, and sleep is granted only from halt. Leaving sleep takes two further bus bit times, and leaving halt takes one. An optional automatic halt fires when the engine drops into bus off. A reset-state flag reports that a hardware or software reset is in progress. While that flag is set, the block ignores mode requests.

Top module: `can_mode_status`

## Requirements
- R1: `reset_flag` is 1 in the cycle after a clock edge that samples `rst_n` low or `sw_reset` high. It is 0 in the cycle after the first edge that samples `rst_n` high and `sw_reset` low.
- R2: One cycle after any edge, `fault_flag` is 1 when the sampled `tec` is at least 128, `rec` is at least 128, `ep_test_mode` is 1 or `bus_off` is 1. Otherwise it is 0, and it is also 0 after any reset.
- R3: While `reset_flag` is 1, `halt_req` and `sleep_req` have no effect and `halt_sleep_flag` stays 0.
- R4: If `halt_req` is 1 while `bus_phase` is idle (2'b00) or intermission (2'b01), `halt_sleep_flag` is 1 one cycle later.
- R5: A halt request made while `bus_phase` is frame (2'b10 or 2'b11) leaves `halt_sleep_flag` at 0 until the phase leaves frame. The flag rises one cycle after that.
- R6: `sleep_req` has no effect unless the block is already halted, so `halt_sleep_flag` stays 0.
- R7: With the block halted, `sleep_req` moves it into sleep and `halt_sleep_flag` stays 1.
- R8: After `sleep_req` is cleared, `halt_sleep_flag` stays 1 until the second `bit_tick` pulse. With `halt_req` low it clears one cycle after that pulse. With `halt_req` still high the block returns to halt and the flag stays 1.
- R9: When `halt_req` is cleared outside sleep, `halt_sleep_flag` stays 1 until a `bit_tick` pulse and clears one cycle after it. The flag never falls without a tick or a reset.
- R10: With `auto_halt_en` and `auto_halt_arm` both 1, a rise of `bus_off` sets `halt_sleep_flag` one cycle later, whatever the bus phase. The halt holds until `bus_off` is low and `halt_req` is low. If either enable is 0, no automatic halt occurs.
- R11: A halt request withdrawn before the frame ends is dropped, and `halt_sleep_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_reset | input | 1 | Software reset request, active high |
| tec | input | 9 | Transmit error counter |
| rec | input | 8 | Receive error counter |
| bus_off | input | 1 | Engine is in bus off |
| bus_phase | input | 2 | 00 idle, 01 intermission, 10/11 frame |
| halt_req | input | 1 | Halt request |
| sleep_req | input | 1 | Sleep request |
| auto_halt_en | input | 1 | Automatic halt on bus off option |
| auto_halt_arm | input | 1 | Companion enable for automatic halt |
| ep_test_mode | input | 1 | Forced error-passive test mode |
| bit_tick | input | 1 | One-cycle pulse per bus bit time |
| fault_flag | output | 1 | Error passive or bus off |
| halt_sleep_flag | output | 1 | Halt or sleep state |
| reset_flag | output | 1 | Reset in progress |

## Verification
Each of the three flags is registered. A flag therefore shows the effect of the inputs sampled at a clock edge in the cycle right after that edge. The mode machine adds no further delay of its own, but the wake-up path waits for two `bit_tick` pulses and the halt-release path waits for one. The bench drives inputs on the falling edge and reads the flags on the next falling edge, so each check sees exactly one rising edge. Checks on the tick paths are placed both before and after the deciding pulse. The fault flag is swept over every transmit counter value up to 300 and every receive counter value, and each result is compared with the threshold computed in the bench.

// File: rtl/can_mode_pkg.sv
// Package: shared types for the CAN mode status tracker.
// Assumes: the bus phase arrives as a 2-bit code and a frame is any code with bit 1 set.
package can_mode_pkg;

    // Bus phase codes as reported by the protocol engine.
    typedef enum logic [1:0] {
        PH_IDLE         = 2'b00,
        PH_INTERMISSION = 2'b01,
        PH_FRAME        = 2'b10,
        PH_FRAME_ALT    = 2'b11
    } bus_phase_e;

    // Mode machine states.
    typedef enum logic [2:0] {
        MS_RUN       = 3'd0,
        MS_HALT_WAIT = 3'd1,
        MS_HALTED    = 3'd2,
        MS_SLEEP     = 3'd3,
        MS_WAKING    = 3'd4,
        MS_UNHALT    = 3'd5
    } mode_state_e;

    // True when the bus is between frames, where halt may be granted.
    function automatic logic at_boundary(input bus_phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_INTERMISSION);
    endfunction

endpackage

// File: rtl/can_reset_track.sv
// Module: reset-state flag.
// Does: reports 1 after any hardware or software reset. It drops on the first
// clock that sees both reset sources released.
// Assumes: rst_n is synchronous and active low, and sw_reset is active high.
module can_reset_track (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_reset,
    output logic in_reset
);

    // Purpose: hold the flag while any reset source is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_reset <= 1'b1;
        end else begin
            in_reset <= sw_reset;
        end
    end

endmodule

// File: rtl/can_fault_conf.sv
// Module: fault confinement flag.
// Does: raises one flag for error passive or bus off. The flag is set when
// either error counter reaches the passive limit, when the test mode forces
// it, or when the engine reports bus off.
// Assumes: the counters come from the engine already saturated or wrapped
// as the engine defines. This module only compares them.
module can_fault_conf #(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int PASSIVE_LIMIT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    input  logic             bus_off,
    input  logic             ep_test_mode,
    output logic             fault_flag
);

    localparam logic [TEC_W-1:0] TEC_LIM = TEC_W'(PASSIVE_LIMIT);
    localparam logic [REC_W-1:0] REC_LIM = REC_W'(PASSIVE_LIMIT);

    logic tec_over;
    logic rec_over;
    logic fault_next;

    // Purpose: compare each counter against the passive limit.
    always_comb begin
        tec_over   = (tec >= TEC_LIM);
        rec_over   = (rec >= REC_LIM);
        fault_next = tec_over | rec_over | ep_test_mode | bus_off;
    end

    // Purpose: register the flag and clear it to error active on any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) begin
            fault_flag <= 1'b0;
        end else begin
            fault_flag <= fault_next;
        end
    end

endmodule

// File: rtl/can_mode_fsm.sv
// Module: halt / sleep mode machine.
// Does: grants halt at a frame boundary and sleep only from halt. Leaving
// sleep takes WAKE_TICKS bit times and leaving halt takes one bit time.
// An automatic halt fires on entry to bus off when both enables are set.
// Assumes: bit_tick is a single-cycle pulse per bus bit. No request is
// honoured while in_reset is 1.
module can_mode_fsm
    import can_mode_pkg::*;
#(
    parameter int WAKE_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_reset,
    input  logic       in_reset,
    input  logic       halt_req,
    input  logic       sleep_req,
    input  logic       auto_halt_en,
    input  logic       auto_halt_arm,
    input  logic       bus_off,
    input  bus_phase_e phase,
    input  logic       bit_tick,
    output logic       halt_sleep
);

    localparam int WK_W = (WAKE_TICKS < 2) ? 1 : $clog2(WAKE_TICKS);
    localparam logic [WK_W-1:0] WK_LAST = WK_W'(WAKE_TICKS - 1);

    mode_state_e state_q, state_d;
    logic [WK_W-1:0] wake_cnt_q, wake_cnt_d;
    logic bus_off_q;
    logic auto_hold_q, auto_hold_d;
    logic auto_fire;
    logic release_ok;

    // Purpose: detect entry into bus off with automatic halt armed.
    always_comb begin
        auto_fire  = auto_halt_en & auto_halt_arm & bus_off & ~bus_off_q;
        release_ok = ~halt_req & ~auto_hold_q;
    end

    // Purpose: next-state, wake counter and auto-hold decisions.
    always_comb begin
        state_d     = state_q;
        wake_cnt_d  = wake_cnt_q;
        auto_hold_d = auto_hold_q;
        if (!bus_off) begin
            auto_hold_d = 1'b0;
        end
        if (in_reset) begin
            state_d     = MS_RUN;
            wake_cnt_d  = '0;
            auto_hold_d = 1'b0;
        end else begin
            unique case (state_q)
                MS_RUN, MS_HALT_WAIT: begin
                    if (auto_fire) begin
                        state_d     = MS_HALTED;
                        auto_hold_d = 1'b1;
                    end else if (!halt_req) begin
                        state_d = MS_RUN;
                    end else if (at_boundary(phase)) begin
                        state_d = MS_HALTED;
                    end else begin
                        state_d = MS_HALT_WAIT;
                    end
                end
                MS_HALTED: begin
                    if (sleep_req) begin
                        state_d = MS_SLEEP;
                    end else if (release_ok) begin
                        state_d = MS_UNHALT;
                    end
                end
                MS_UNHALT: begin
                    if (!release_ok) begin
                        state_d = MS_HALTED;
                    end else if (bit_tick) begin
                        state_d = MS_RUN;
                    end
                end
                MS_SLEEP: begin
                    if (!sleep_req) begin
                        state_d    = MS_WAKING;
                        wake_cnt_d = '0;
                    end
                end
                MS_WAKING: begin
                    if (sleep_req) begin
                        state_d = MS_SLEEP;
                    end else if (bit_tick) begin
                        if (wake_cnt_q == WK_LAST) begin
                            state_d    = release_ok ? MS_RUN : MS_HALTED;
                            wake_cnt_d = '0;
                        end else begin
                            wake_cnt_d = wake_cnt_q + 1'b1;
                        end
                    end
                end
                default: state_d = MS_RUN;
            endcase
        end
    end

    // Purpose: state registers, returned to run on any reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_reset) begin
            state_q     <= MS_RUN;
            wake_cnt_q  <= '0;
            auto_hold_q <= 1'b0;
            bus_off_q   <= 1'b0;
        end else begin
            state_q     <= state_d;
            wake_cnt_q  <= wake_cnt_d;
            auto_hold_q <= auto_hold_d;
            bus_off_q   <= bus_off;
        end
    end

    // Purpose: decode the externally visible halt/sleep flag.
    always_comb begin
        halt_sleep = (state_q == MS_HALTED) || (state_q == MS_SLEEP) ||
                     (state_q == MS_WAKING) || (state_q == MS_UNHALT);
    end

endmodule

// File: rtl/can_mode_status.sv
// Module: CAN controller mode status tracker (top).
// Does: combines the reset tracker, the fault confinement flag and the
// halt/sleep mode machine into three global status flags.
// Assumes: all inputs are synchronous to clk.
module can_mode_status
    import can_mode_pkg::*;
#(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int PASSIVE_LIMIT = 128,
    parameter int WAKE_TICKS    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic [TEC_W-1:0] tec,
    input  logic [REC_W-1:0] rec,
    input  logic             bus_off,
    input  logic [1:0]       bus_phase,
    input  logic             halt_req,
    input  logic             sleep_req,
    input  logic             auto_halt_en,
    input  logic             auto_halt_arm,
    input  logic             ep_test_mode,
    input  logic             bit_tick,
    output logic             fault_flag,
    output logic             halt_sleep_flag,
    output logic             reset_flag
);

    bus_phase_e phase;

    // Purpose: view the raw phase code as the package enum.
    always_comb begin
        phase = bus_phase_e'(bus_phase);
    end

    can_reset_track u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_reset (sw_reset),
        .in_reset (reset_flag)
    );

    can_fault_conf #(
        .TEC_W         (TEC_W),
        .REC_W         (REC_W),
        .PASSIVE_LIMIT (PASSIVE_LIMIT)
    ) u_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_reset     (sw_reset),
        .tec          (tec),
        .rec          (rec),
        .bus_off      (bus_off),
        .ep_test_mode (ep_test_mode),
        .fault_flag   (fault_flag)
    );

    can_mode_fsm #(
        .WAKE_TICKS (WAKE_TICKS)
    ) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_reset      (sw_reset),
        .in_reset      (reset_flag),
        .halt_req      (halt_req),
        .sleep_req     (sleep_req),
        .auto_halt_en  (auto_halt_en),
        .auto_halt_arm (auto_halt_arm),
        .bus_off       (bus_off),
        .phase         (phase),
        .bit_tick      (bit_tick),
        .halt_sleep    (halt_sleep_flag)
    );

endmodule

// File: rtl/can_mode_status_chk.sv
// Module: assertion checker for can_mode_status, attached by bind.
// Does: checks the flag timing rules at the ports of the top module.
module can_mode_status_chk #(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int PASSIVE_LIMIT = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_reset,
    input logic [TEC_W-1:0] tec,
    input logic [REC_W-1:0] rec,
    input logic             bus_off,
    input logic [1:0]       bus_phase,
    input logic             halt_req,
    input logic             ep_test_mode,
    input logic             bit_tick,
    input logic             fault_flag,
    input logic             halt_sleep_flag,
    input logic             reset_flag
);

    localparam logic [TEC_W-1:0] TEC_LIM = TEC_W'(PASSIVE_LIMIT);
    localparam logic [REC_W-1:0] REC_LIM = REC_W'(PASSIVE_LIMIT);

    // R1
    sw_reset_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> reset_flag);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_reset |=> !reset_flag);

    // R2
    fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_reset && (tec >= TEC_LIM || rec >= REC_LIM)) |=> fault_flag);

    // R2
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tec < TEC_LIM && rec < REC_LIM && !ep_test_mode && !bus_off) |=> !fault_flag);

    // R3
    reset_blocks_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_flag |-> !halt_sleep_flag);

    // R4
    halt_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !reset_flag && !sw_reset && !bus_phase[1]) |=> halt_sleep_flag);

    // R5
    no_halt_mid_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_sleep_flag && bus_phase[1] && !bus_off) |=> !halt_sleep_flag);

    // R9
    flag_falls_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_sleep_flag && !bit_tick && !sw_reset) |=> halt_sleep_flag);

endmodule

bind can_mode_status can_mode_status_chk #(
    .TEC_W         (TEC_W),
    .REC_W         (REC_W),
    .PASSIVE_LIMIT (PASSIVE_LIMIT)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sw_reset        (sw_reset),
    .tec             (tec),
    .rec             (rec),
    .bus_off         (bus_off),
    .bus_phase       (bus_phase),
    .halt_req        (halt_req),
    .ep_test_mode    (ep_test_mode),
    .bit_tick        (bit_tick),
    .fault_flag      (fault_flag),
    .halt_sleep_flag (halt_sleep_flag),
    .reset_flag      (reset_flag)
);

// File: tb/can_mode_status_tb.sv
// Bench: drives on the falling edge and samples on the next falling edge.
module can_mode_status_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_reset;
    logic [8:0] tec;
    logic [7:0] rec;
    logic       bus_off;
    logic [1:0] bus_phase;
    logic       halt_req;
    logic       sleep_req;
    logic       auto_halt_en;
    logic       auto_halt_arm;
    logic       ep_test_mode;
    logic       bit_tick;
    logic       fault_flag;
    logic       halt_sleep_flag;
    logic       reset_flag;

    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    can_mode_status u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sw_reset        (sw_reset),
        .tec             (tec),
        .rec             (rec),
        .bus_off         (bus_off),
        .bus_phase       (bus_phase),
        .halt_req        (halt_req),
        .sleep_req       (sleep_req),
        .auto_halt_en    (auto_halt_en),
        .auto_halt_arm   (auto_halt_arm),
        .ep_test_mode    (ep_test_mode),
        .bit_tick        (bit_tick),
        .fault_flag      (fault_flag),
        .halt_sleep_flag (halt_sleep_flag),
        .reset_flag      (reset_flag)
    );

    task automatic check(input string req, input logic act, input logic exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One rising edge, then back to the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        step();
        bit_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sw_reset = 1'b0; tec = '0; rec = '0; bus_off = 1'b0;
        bus_phase = 2'b00; halt_req = 1'b0; sleep_req = 1'b0;
        auto_halt_en = 1'b0; auto_halt_arm = 1'b0; ep_test_mode = 1'b0;
        bit_tick = 1'b0;
        @(negedge clk);
        step(); step();
        check("R1 reset flag set", reset_flag, 1'b1);
        check("R2 fault clear in reset", fault_flag, 1'b0);
        check("R3 halt flag clear in reset", halt_sleep_flag, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 reset flag released", reset_flag, 1'b0);

        // R3: requests ignored under software reset
        sw_reset = 1'b1; halt_req = 1'b1;
        step();
        check("R1 sw reset sets flag", reset_flag, 1'b1);
        check("R3 halt ignored", halt_sleep_flag, 1'b0);
        step();
        check("R3 halt ignored", halt_sleep_flag, 1'b0);
        sw_reset = 1'b0;
        step();
        check("R1 sw reset released", reset_flag, 1'b0);
        check("R3 halt ignored on release edge", halt_sleep_flag, 1'b0);
        step();
        check("R4 halt at idle", halt_sleep_flag, 1'b1);

        // R9: release waits for a tick
        halt_req = 1'b0;
        step(); step();
        check("R9 held before tick", halt_sleep_flag, 1'b1);
        tick();
        check("R9 cleared after tick", halt_sleep_flag, 1'b0);

        // R2: counter sweeps
        for (int t = 0; t <= 300; t++) begin
            tec = 9'(t);
            step();
            check("R2 tec sweep", fault_flag, t >= 128);
        end
        tec = '0;
        for (int r = 0; r <= 255; r++) begin
            rec = 8'(r);
            step();
            check("R2 rec sweep", fault_flag, r >= 128);
        end
        rec = '0;
        ep_test_mode = 1'b1; step();
        check("R2 test mode", fault_flag, 1'b1);
        ep_test_mode = 1'b0; step();
        check("R2 test mode off", fault_flag, 1'b0);
        bus_off = 1'b1; step();
        check("R2 bus off", fault_flag, 1'b1);
        bus_off = 1'b0; step();
        check("R2 bus off cleared", fault_flag, 1'b0);

        // R6: sleep without halt is ignored
        sleep_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R6 sleep ignored", halt_sleep_flag, 1'b0);
        end
        sleep_req = 1'b0;

        // R11: halt withdrawn mid-frame
        bus_phase = 2'b10; halt_req = 1'b1; step();
        halt_req = 1'b0; step();
        bus_phase = 2'b00; step();
        check("R11 withdrawn halt dropped", halt_sleep_flag, 1'b0);

        // R5: halt waits for intermission
        bus_phase = 2'b11; halt_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R5 no halt mid-frame", halt_sleep_flag, 1'b0);
        end
        bus_phase = 2'b01; step();
        check("R5 halt at intermission", halt_sleep_flag, 1'b1);

        // R7/R8: sleep then wake with halt released
        sleep_req = 1'b1; step();
        check("R7 sleep from halt", halt_sleep_flag, 1'b1);
        halt_req = 1'b0; step();
        check("R7 sleep held", halt_sleep_flag, 1'b1);
        sleep_req = 1'b0; step();
        check("R8 waking", halt_sleep_flag, 1'b1);
        tick();
        check("R8 one tick", halt_sleep_flag, 1'b1);
        step(); step();
        check("R8 between ticks", halt_sleep_flag, 1'b1);
        tick();
        check("R8 awake after two ticks", halt_sleep_flag, 1'b0);

        // R8: wake with halt still requested
        halt_req = 1'b1; step();
        sleep_req = 1'b1; step();
        sleep_req = 1'b0; step();
        tick(); tick(); step();
        check("R8 back to halt", halt_sleep_flag, 1'b1);
        halt_req = 1'b0; step();
        tick();
        check("R9 release after wake", halt_sleep_flag, 1'b0);

        // R10: auto halt needs both enables
        bus_phase = 2'b10; auto_halt_en = 1'b1;
        bus_off = 1'b1; step();
        check("R10 one enable no halt", halt_sleep_flag, 1'b0);
        bus_off = 1'b0; step();
        auto_halt_arm = 1'b1; bus_off = 1'b1; step();
        check("R10 auto halt mid-frame", halt_sleep_flag, 1'b1);
        tick(); tick();
        check("R10 held during bus off", halt_sleep_flag, 1'b1);
        bus_off = 1'b0; step(); step();
        check("R10 held until tick", halt_sleep_flag, 1'b1);
        tick();
        check("R10 released", halt_sleep_flag, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule